// File: doc/BRIEF.md
# Dual-Slot Packet Memory Sequencer

This block runs the two memory operations of one execute packet in a fixed order against a small byte-addressable memory. Slot 1 may carry a store and slot 0 may carry a load. The store is committed first and the load reads afterwards, so a load whose bytes overlap the store returns the freshly written bytes. Before the store is allowed to commit, the load address is probed. A load that would fault blocks the store. Predicated operations whose predicate bit is false are cancelled and reported in a per-slot cancel mask.

A packet enters through a valid/ready handshake. `pkt_ready` is high only while the sequencer is idle, and a packet is taken on a clock edge where `pkt_valid` and `pkt_ready` are both high. The result leaves through a second valid/ready handshake. `res_valid` stays high, with its payload frozen, until the consumer raises `res_ready`. A new packet is accepted only after that handshake, so back-pressure on the result stalls the packet input.

The memory is little-endian and clears to zero on reset. Store bytes that fall beyond the end of the memory are dropped.

Top module: `msq_packet_seq`

## Requirements
- R1: `pkt_ready` is high only when no result is pending. `res_valid` rises after the second clock edge that follows the accepting edge. It then holds, with `res_load_data`, `res_cancel` and `res_fault` stable, until a cycle with `res_ready` high. `pkt_ready` is high again after that edge.
- R2: An active store is committed before the active load of the same packet reads. Overlapping bytes return the new store data, and all other bytes return earlier memory contents.
- R3: After reset every memory byte reads zero. Memory is little-endian: byte i of a datum sits at address+i. A store of n bytes changes only addresses addr..addr+n-1.
- R4: The size code gives the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Loads of 1, 2 or 4 bytes are sign-extended to 64 bits when `ld_signed` is 1 and zero-extended when it is 0. An 8-byte load ignores `ld_signed`.
- R5: An active load faults when its address is not a multiple of its width, or when address+width exceeds the memory size (64 bytes by default). A fault sets `res_fault`, returns load data 0 and prevents the store from writing memory.
- R6: A predicated load with `ld_pred`=0 is not probed and never faults. The store of the packet is still performed, the load returns 0, and bit 0 of the cancel mask is set.
- R7: If such a cancelled load has `ld_endloop`=1, bit 4 of the cancel mask is set instead of bit 0.
- R8: A predicated store with `st_pred`=0 sets bit 1 of the cancel mask and writes nothing. A load in the same packet reads the unmodified memory.
- R9: The cancel mask starts cleared for every packet. A true predicate, or an unpredicated operation, sets no bit, and bits 2 and 3 are always 0.
- R10: A slot whose valid bit is 0 does nothing and sets no cancel bit. An absent load returns 0 and never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Sequencer idle, packet can be taken |
| st_valid | input | 1 | Slot 1 holds a store |
| st_predicated | input | 1 | Store is predicated |
| st_pred | input | 1 | Store predicate LSB |
| st_addr | input | 8 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, low bytes used |
| ld_valid | input | 1 | Slot 0 holds a load |
| ld_predicated | input | 1 | Load is predicated |
| ld_pred | input | 1 | Load predicate LSB |
| ld_endloop | input | 1 | Load is an end-of-loop instruction |
| ld_addr | input | 8 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_signed | input | 1 | Sign-extend the load |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_load_data | output | 64 | Extended load data |
| res_cancel | output | 5 | Cancel mask (bit 0 load, bit 1 store, bit 4 end-of-loop) |
| res_fault | output | 1 | Load fault, store suppressed |

## Verification
Take k as the edge that accepts a packet. The probe and the store commit happen at edge k+1. The read and extension are registered at edge k+2, so the result is visible from edge k+2 onward. The bench samples on falling edges. It expects `res_valid` low after edges k and k+1 and high after k+2, and compares the payload there. For some packets it then withholds `res_ready` for several cycles and checks that the payload stays unchanged. A reference byte array in the bench is updated only when the requirements say the store commits. Every expected load value is assembled and extended from that array.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_COMMIT = 2'd1,
    SQ_READ   = 2'd2,
    SQ_RESP   = 2'd3
  } seq_state_e;

  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;

  // size code to byte count: 0->1, 1->2, 2->4, 3->8
  function automatic logic [3:0] code_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/msq_fault_probe.sv
module msq_fault_probe #(
  parameter int ADDR_W    = 8,
  parameter int MEM_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              bad
);
  localparam int END_W = ADDR_W + 1;

  logic [2:0]       low_mask;
  logic [END_W-1:0] end_excl;
  logic             misaligned;
  logic             beyond;

  always_comb begin
    low_mask   = 3'(msq_pkg::code_bytes(size) - 4'd1);
    misaligned = |(addr[2:0] & low_mask);
    end_excl   = END_W'(addr) + END_W'(msq_pkg::code_bytes(size));
    beyond     = end_excl > END_W'(MEM_BYTES);
    bad        = misaligned || beyond;
  end
endmodule

// File: rtl/msq_byte_mem.sv
module msq_byte_mem #(
  parameter int ADDR_W    = 8,
  parameter int MEM_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data
);
  localparam int OFS_W = ADDR_W + 1;
  localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  logic [7:0]           cells   [MEM_BYTES];
  logic [7:0]           cell_wd [MEM_BYTES];
  logic [MEM_BYTES-1:0] cell_we;

  // per-cell write decode: cell b is hit when 0 <= b-addr < width
  for (genvar b = 0; b < MEM_BYTES; b++) begin : g_cell
    logic [OFS_W-1:0] ofs;
    assign ofs        = OFS_W'(b) - OFS_W'(wr_addr);
    assign cell_we[b] = we && (ofs < (OFS_W'(1) << wr_size));
    assign cell_wd[b] = wr_data[{ofs[2:0], 3'b000} +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) cells[i] <= 8'h00;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++)
        if (cell_we[i]) cells[i] <= cell_wd[i];
    end
  end

  // little-endian read of eight consecutive bytes, zero past the end
  for (genvar j = 0; j < msq_pkg::LANES; j++) begin : g_lane
    logic [OFS_W-1:0] idx;
    assign idx = OFS_W'(rd_addr) + OFS_W'(j);
    assign rd_data[8*j +: 8] = (idx < OFS_W'(MEM_BYTES)) ? cells[idx[IDX_W-1:0]] : 8'h00;
  end
endmodule

// File: rtl/msq_load_ext.sv
module msq_load_ext (
  input  logic [63:0] raw,
  input  logic [1:0]  size,
  input  logic        sgn,
  output logic [63:0] value
);
  always_comb begin
    case (size)
      2'd0:    value = sgn ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
      2'd1:    value = sgn ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
      2'd2:    value = sgn ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
      default: value = raw;
    endcase
  end
endmodule

// File: rtl/msq_packet_seq.sv
module msq_packet_seq import msq_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int MEM_BYTES = 64,
  parameter int LD_SLOT   = 0,
  parameter int ST_SLOT   = 1,
  parameter int LOOP_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic              st_valid,
  input  logic              st_predicated,
  input  logic              st_pred,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [63:0]       st_data,
  input  logic              ld_valid,
  input  logic              ld_predicated,
  input  logic              ld_pred,
  input  logic              ld_endloop,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_signed,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [63:0]       res_load_data,
  output logic [LOOP_BIT:0] res_cancel,
  output logic              res_fault
);
  localparam int CANCEL_W = LOOP_BIT + 1;
  localparam logic [CANCEL_W-1:0] USED_BITS =
    CANCEL_W'((1 << LD_SLOT) | (1 << ST_SLOT) | (1 << LOOP_BIT));

  seq_state_e state;

  // captured packet
  logic              st_v_q, st_p_q, st_pr_q;
  logic [ADDR_W-1:0] st_a_q;
  logic [1:0]        st_s_q;
  logic [63:0]       st_d_q;
  logic              ld_v_q, ld_p_q, ld_pr_q, ld_e_q, ld_sg_q;
  logic [ADDR_W-1:0] ld_a_q;
  logic [1:0]        ld_s_q;

  logic                st_live, ld_live, probe_bad, ld_fault, mem_we;
  logic [CANCEL_W-1:0] cancel_nxt;
  logic [63:0]         mem_rd, ext_val;

  assign pkt_ready = (state == SQ_IDLE);
  assign res_valid = (state == SQ_RESP);

  msq_fault_probe #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_probe (
    .addr (ld_a_q),
    .size (ld_s_q),
    .bad  (probe_bad)
  );

  always_comb begin
    st_live  = st_v_q && (!st_p_q || st_pr_q);
    ld_live  = ld_v_q && (!ld_p_q || ld_pr_q);
    // probe only a load that will really execute
    ld_fault = ld_live && probe_bad;
    mem_we   = (state == SQ_COMMIT) && st_live && !ld_fault;
    cancel_nxt = '0;
    if (st_v_q && st_p_q && !st_pr_q) cancel_nxt[ST_SLOT] = 1'b1;
    if (ld_v_q && ld_p_q && !ld_pr_q) begin
      if (ld_e_q) cancel_nxt[LOOP_BIT] = 1'b1;
      else        cancel_nxt[LD_SLOT]  = 1'b1;
    end
  end

  msq_byte_mem #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .wr_addr (st_a_q),
    .wr_size (st_s_q),
    .wr_data (st_d_q),
    .rd_addr (ld_a_q),
    .rd_data (mem_rd)
  );

  msq_load_ext u_ext (
    .raw   (mem_rd),
    .size  (ld_s_q),
    .sgn   (ld_sg_q),
    .value (ext_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= SQ_IDLE;
      st_v_q        <= 1'b0;
      st_p_q        <= 1'b0;
      st_pr_q       <= 1'b0;
      st_a_q        <= '0;
      st_s_q        <= '0;
      st_d_q        <= '0;
      ld_v_q        <= 1'b0;
      ld_p_q        <= 1'b0;
      ld_pr_q       <= 1'b0;
      ld_e_q        <= 1'b0;
      ld_sg_q       <= 1'b0;
      ld_a_q        <= '0;
      ld_s_q        <= '0;
      res_load_data <= '0;
      res_cancel    <= '0;
      res_fault     <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (pkt_valid) begin
          st_v_q  <= st_valid;
          st_p_q  <= st_predicated;
          st_pr_q <= st_pred;
          st_a_q  <= st_addr;
          st_s_q  <= st_size;
          st_d_q  <= st_data;
          ld_v_q  <= ld_valid;
          ld_p_q  <= ld_predicated;
          ld_pr_q <= ld_pred;
          ld_e_q  <= ld_endloop;
          ld_sg_q <= ld_signed;
          ld_a_q  <= ld_addr;
          ld_s_q  <= ld_size;
          state   <= SQ_COMMIT;
        end
        SQ_COMMIT: begin
          res_fault  <= ld_fault;
          res_cancel <= cancel_nxt;
          state      <= SQ_READ;
        end
        SQ_READ: begin
          res_load_data <= (ld_live && !res_fault) ? ext_val : 64'd0;
          state         <= SQ_RESP;
        end
        default: if (res_ready) state <= SQ_IDLE;
      endcase
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> !res_valid); // R1
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_valid && pkt_ready, 3) |-> res_valid); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_load_data) &&
    $stable(res_cancel) && $stable(res_fault)); // R1
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_load_data == 64'd0); // R5
  AST_FAULT_NOT_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> !res_cancel[LD_SLOT] && !res_cancel[LOOP_BIT]); // R6
  AST_LOOP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_cancel[LD_SLOT] && res_cancel[LOOP_BIT])); // R7
  AST_SPARE_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cancel & ~USED_BITS) == '0); // R9
endmodule

// File: tb/sim_msq_packet_seq.sv
module sim_msq_packet_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB       = 64;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic        st_valid = 1'b0, st_predicated = 1'b0, st_pred = 1'b0;
  logic [7:0]  st_addr = '0;
  logic [1:0]  st_size = '0;
  logic [63:0] st_data = '0;
  logic        ld_valid = 1'b0, ld_predicated = 1'b0, ld_pred = 1'b0, ld_endloop = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        ld_signed = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_load_data;
  logic [4:0]  res_cancel;
  logic        res_fault;

  int tests = 0;
  int fails = 0;
  logic [7:0] ref_mem [MEMB];

  always #(CLK_PERIOD/2) clk = ~clk;

  msq_packet_seq u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .st_valid(st_valid), .st_predicated(st_predicated), .st_pred(st_pred),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .ld_valid(ld_valid), .ld_predicated(ld_predicated), .ld_pred(ld_pred),
    .ld_endloop(ld_endloop), .ld_addr(ld_addr), .ld_size(ld_size), .ld_signed(ld_signed),
    .res_valid(res_valid), .res_ready(res_ready), .res_load_data(res_load_data),
    .res_cancel(res_cancel), .res_fault(res_fault)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_pkt(input logic sv, input logic sp, input logic spr, input logic [7:0] sa,
                        input logic [1:0] ss, input logic [63:0] sd,
                        input logic lv, input logic lp, input logic lpr, input logic le,
                        input logic [7:0] la, input logic [1:0] ls, input logic lsg,
                        input int hold, input string tag);
    logic st_act, ld_act, e_fault;
    logic [4:0] e_cancel;
    logic [63:0] e_data;
    int n, sn;
    st_act = sv && (!sp || spr);
    ld_act = lv && (!lp || lpr);
    n  = 1 << ls;
    sn = 1 << ss;
    e_fault = ld_act && (((int'(la) % n) != 0) || (int'(la) + n > MEMB));
    e_cancel = '0;
    if (sv && sp && !spr) e_cancel[1] = 1'b1;                  // R8
    if (lv && lp && !lpr) e_cancel[le ? 4 : 0] = 1'b1;         // R6 R7
    if (st_act && !e_fault)
      for (int i = 0; i < sn; i++)
        if (int'(sa) + i < MEMB) ref_mem[int'(sa) + i] = sd[8*i +: 8];
    e_data = '0;
    if (ld_act && !e_fault) begin
      for (int i = 0; i < n; i++) e_data[8*i +: 8] = ref_mem[int'(la) + i];
      if (lsg && n < 8 && e_data[8*n-1]) e_data = e_data | ~((64'd1 << (8*n)) - 64'd1);
    end

    @(negedge clk);
    chk("R1 ready before packet", 64'(pkt_ready), 64'd1);
    st_valid = sv; st_predicated = sp; st_pred = spr; st_addr = sa; st_size = ss; st_data = sd;
    ld_valid = lv; ld_predicated = lp; ld_pred = lpr; ld_endloop = le;
    ld_addr = la; ld_size = ls; ld_signed = lsg;
    pkt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk("R1 no result after accept edge", 64'(res_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 no result one edge later", 64'(res_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 result due", 64'(res_valid), 64'd1);
    chk(tag, res_load_data, e_data);
    chk("R9 cancel mask", 64'(res_cancel), 64'(e_cancel));
    chk("R5 fault flag", 64'(res_fault), 64'(e_fault));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R1 held valid", 64'(res_valid), 64'd1);
      chk("R1 held data", res_load_data, e_data);
      chk("R1 input stalled", 64'(pkt_ready), 64'd0);
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R1 ready after handshake", 64'(pkt_ready), 64'd1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    int cnt;
    logic [7:0] sa_list [2];
    for (int i = 0; i < MEMB; i++) ref_mem[i] = 8'h00;
    sa_list[0] = 8'd16;
    sa_list[1] = 8'd19;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset ready", 64'(pkt_ready), 64'd1);
    chk("R1 reset no result", 64'(res_valid), 64'd0);
    // R3: memory empty after reset; R10: absent store
    do_pkt(1'b0, 1'b0, 1'b0, 8'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF,
           1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 2'd3, 1'b0, 0, "R3 R10 reset memory zero");
    // R1: back-pressure on the result
    do_pkt(1'b1, 1'b0, 1'b0, 8'd8, 2'd2, 64'h0000_0000_8765_4321,
           1'b1, 1'b0, 1'b0, 1'b0, 8'd8, 2'd2, 1'b1, 3, "R1 R2 held result");
    // R2 R3 R4 R5: size, sign and address sweep with store before load
    cnt = 0;
    for (int s = 0; s < 2; s++)
      for (int ss = 0; ss < 4; ss++)
        for (int ls = 0; ls < 4; ls++)
          for (int sg = 0; sg < 2; sg++)
            for (int la = 0; la < MEMB; la++) begin
              cnt++;
              pat = 64'hF1E2_D3C4_B5A6_9788 ^ (64'(cnt) * 64'h0123_4567_89AB_CDEF);
              do_pkt(1'b1, 1'b0, 1'b0, sa_list[s], 2'(ss), pat,
                     1'b1, 1'b0, 1'b0, 1'b0, 8'(la), 2'(ls), 1'(sg), 0, "R2 R3 R4 R5 load data");
            end
    // R6 R7 R8 R9 R10: every combination of valid, predication, predicate and end-of-loop
    for (int fa = 0; fa < 2; fa++)
      for (int c = 0; c < 128; c++) begin
        pat = 64'h5A3C_96E1_0F7B_2D48 + 64'(c * 977 + fa);
        do_pkt(c[0], c[1], c[2], 8'd17, 2'd3, pat,
               c[3], c[4], c[5], c[6], fa ? 8'd62 : 8'd16, 2'd2, 1'b1,
               (c % 17 == 0) ? 2 : 0, "R6 R7 R8 R10 predicated data");
      end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule